// File: doc/BRIEF.md
# Belt Operand Store with Call Frames

This block keeps the operand values of a belt-style processor. The belt is a fixed row of eight positions. Position 0 is the head and holds the newest value. A result is dropped at the head, every older value moves one position toward the tail, and the value in the last position is lost. Operands are read by position through indexed read ports. The read is combinational. Each belt entry carries a valid bit, and a cleared valid bit marks the slot as holding no value (not-a-value, NaR).

A call saves the whole caller belt on an internal frame stack. It then starts the callee with a fresh belt that holds only the selected arguments, so none of the caller's other operands can be seen. A return pops the saved belt and puts the selected callee values back at its head. Everything else the callee held is thrown away.

Each cycle, a combinational decode picks one operation: OP_IDLE, OP_DROP, OP_CALL or OP_RET. The belt register loads its next value on the clock edge, so every operation takes one cycle. OP_CALL changes the belt only when the frame stack has room. OP_RET changes the belt only when the stack holds a frame. A call that finds the stack full, or a return that finds it empty, leaves all state alone and raises an error pulse. The frame stack moves between empty, partly filled and full. A call moves it one step toward full, and a return moves it one step back toward empty.

Top module: `belt_frame_unit`

## Requirements
- R1: After reset, every belt position reads as NaR (valid 0, data 0), and the frame stack holds no frames.
- R2: Read port p returns the entry at position `rd_idx[p]`, counted from the head at 0, in the same cycle. An index of 8 or more reads as NaR (valid 0, data 0).
- R3: A drop puts `drop_data` at position 0 with valid set. The entry at position n moves to position n+1, and the entry at position 7 is lost. The new belt is visible from the cycle after the command.
- R4: An accepted call gives the callee a belt whose position k holds the caller entry named by `call_idx[k]`, for each k below the count. Element k of the index list occupies bits [4k+3:4k]. An index of 8 or more gives NaR.
- R5: After an accepted call, every position at or above the count reads as NaR. A count above 4 is treated as 4.
- R6: An accepted return builds a new belt. Position k, for k below `ret_cnt`, holds the callee entry named by `ret_idx[k]`, and an index of 8 or more gives NaR. Saved caller position n moves to position n+`ret_cnt`, and any entry that would land past position 7 is lost. Callee entries not named are lost.
- R7: Saved belts are restored in last-in, first-out order, and up to 4 frames can be nested.
- R8: A call made while 4 frames are saved leaves the belt and the stack unchanged. It raises `err_overflow` for exactly the next cycle.
- R9: A return made while no frame is saved leaves the belt unchanged and raises `err_underflow` for exactly the next cycle.
- R10: At most one operation is carried out per cycle. Call has priority over return, and return has priority over drop. A command that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| drop_valid | input | 1 | Drop a result this cycle |
| drop_data | input | 16 | Result value to drop |
| rd_idx | input | 2x4 | Belt position for each read port |
| rd_data | output | 2x16 | Data at each read position |
| rd_valid | output | 2 | Valid bit at each read position (0 = NaR) |
| call_valid | input | 1 | Call command |
| call_cnt | input | 3 | Number of arguments (values above 4 are clamped to 4) |
| call_idx | input | 4x4 | Caller positions passed as arguments |
| ret_valid | input | 1 | Return command |
| ret_cnt | input | 3 | Number of return values (values above 4 are clamped to 4) |
| ret_idx | input | 4x4 | Callee positions passed back |
| err_overflow | output | 1 | One-cycle pulse: a call found the frame stack full |
| err_underflow | output | 1 | One-cycle pulse: a return found the frame stack empty |

## Verification
The hardest condition to reach from the ports is the overflow boundary. The bench can only get there through four accepted calls in a row, and each call wipes out most of the belt. To make the later returns show their order, the stimulus drops a distinct marker value before each nested call and passes that marker as the only argument. Each return then carries the marker back, so the four returns expose the last-in, first-out order one marker at a time. An overflowing call is also issued with a drop in the same cycle, which shows that the losing drop has no effect.

// File: rtl/belt_pkg.sv
package belt_pkg;
    localparam int BELT_DATA_W = 16;

    typedef struct packed {
        logic                   valid;
        logic [BELT_DATA_W-1:0] data;
    } belt_entry_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_DROP,
        OP_CALL,
        OP_RET
    } belt_op_e;
endpackage

// File: rtl/belt_pick.sv
module belt_pick
    import belt_pkg::*;
#(
    parameter int LEN   = 8,
    parameter int IDX_W = 4
) (
    input  belt_entry_t [LEN-1:0] belt_in,
    input  logic [IDX_W-1:0]      idx,
    output belt_entry_t           pick
);
    // An index that matches no position yields an empty (NaR) entry
    always_comb begin
        pick = '0;
        for (int i = 0; i < LEN; i++) begin
            if (idx == IDX_W'(i)) pick = belt_in[i];
        end
    end
endmodule

// File: rtl/belt_frame_stack.sv
module belt_frame_stack
    import belt_pkg::*;
#(
    parameter int LEN   = 8,
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic                  pop,
    input  belt_entry_t [LEN-1:0] push_belt,
    output belt_entry_t [LEN-1:0] top_belt,
    output logic                  full,
    output logic                  empty
);
    localparam int SP_W = $clog2(DEPTH + 1);

    belt_entry_t [LEN-1:0] frames [DEPTH];
    logic [SP_W-1:0]       sp;

    assign full  = (sp == SP_W'(DEPTH));
    assign empty = (sp == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               sp <= '0;
        else if (push && !full)   sp <= sp + SP_W'(1);
        else if (pop && !empty)   sp <= sp - SP_W'(1);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && !full && sp == SP_W'(i)) frames[i] <= push_belt;
        end
    end

    always_comb begin
        top_belt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp == SP_W'(i + 1)) top_belt = frames[i];
        end
    end
endmodule

// File: rtl/belt_frame_unit.sv
module belt_frame_unit
    import belt_pkg::*;
#(
    parameter int BELT_LEN    = 8,
    parameter int STACK_DEPTH = 4,
    parameter int MAX_ARGS    = 4,
    parameter int NUM_RD      = 2,
    parameter int IDX_W       = $clog2(BELT_LEN) + 1,
    parameter int CNT_W       = $clog2(MAX_ARGS + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  drop_valid,
    input  logic [BELT_DATA_W-1:0]                drop_data,
    input  logic [NUM_RD-1:0][IDX_W-1:0]          rd_idx,
    output logic [NUM_RD-1:0][BELT_DATA_W-1:0]    rd_data,
    output logic [NUM_RD-1:0]                     rd_valid,
    input  logic                                  call_valid,
    input  logic [CNT_W-1:0]                      call_cnt,
    input  logic [MAX_ARGS-1:0][IDX_W-1:0]        call_idx,
    input  logic                                  ret_valid,
    input  logic [CNT_W-1:0]                      ret_cnt,
    input  logic [MAX_ARGS-1:0][IDX_W-1:0]        ret_idx,
    output logic                                  err_overflow,
    output logic                                  err_underflow
);
    localparam int ENT_W = $bits(belt_entry_t);

    belt_entry_t [BELT_LEN-1:0] belt_q, belt_d;
    belt_entry_t [BELT_LEN-1:0] arg_pick, res_pick;
    belt_entry_t [BELT_LEN-1:0] saved_belt, saved_shift;
    belt_entry_t [NUM_RD-1:0]   rd_pick;
    belt_op_e                   op;
    logic                       stk_full, stk_empty;
    logic                       call_ok, ret_ok;
    logic [CNT_W-1:0]           call_n, ret_n;

    // Read ports
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        belt_pick #(.LEN(BELT_LEN), .IDX_W(IDX_W)) u_rd_pick (
            .belt_in (belt_q),
            .idx     (rd_idx[g]),
            .pick    (rd_pick[g])
        );
        assign rd_data[g]  = rd_pick[g].data;
        assign rd_valid[g] = rd_pick[g].valid;
    end

    // Argument and result selectors, padded to the belt length with NaR
    for (genvar g = 0; g < BELT_LEN; g++) begin : g_sel
        if (g < MAX_ARGS) begin : g_live
            belt_pick #(.LEN(BELT_LEN), .IDX_W(IDX_W)) u_arg_pick (
                .belt_in (belt_q),
                .idx     (call_idx[g]),
                .pick    (arg_pick[g])
            );
            belt_pick #(.LEN(BELT_LEN), .IDX_W(IDX_W)) u_res_pick (
                .belt_in (belt_q),
                .idx     (ret_idx[g]),
                .pick    (res_pick[g])
            );
        end else begin : g_pad
            assign arg_pick[g] = '0;
            assign res_pick[g] = '0;
        end
    end

    belt_frame_stack #(.LEN(BELT_LEN), .DEPTH(STACK_DEPTH)) u_frames (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (call_ok),
        .pop       (ret_ok),
        .push_belt (belt_q),
        .top_belt  (saved_belt),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    assign call_n = (call_cnt > CNT_W'(MAX_ARGS)) ? CNT_W'(MAX_ARGS) : call_cnt;
    assign ret_n  = (ret_cnt  > CNT_W'(MAX_ARGS)) ? CNT_W'(MAX_ARGS) : ret_cnt;

    // Caller belt moved toward the tail by the number of return values
    assign saved_shift = saved_belt << (ENT_W * int'(ret_n));

    // Operation decode: call > return > drop
    always_comb begin
        if (call_valid)      op = OP_CALL;
        else if (ret_valid)  op = OP_RET;
        else if (drop_valid) op = OP_DROP;
        else                 op = OP_IDLE;
    end

    assign call_ok = (op == OP_CALL) && !stk_full;
    assign ret_ok  = (op == OP_RET)  && !stk_empty;

    // Next belt
    always_comb begin
        belt_d = belt_q;
        unique case (op)
            OP_IDLE: begin
                belt_d = belt_q;
            end
            OP_DROP: begin
                belt_d[0] = {1'b1, drop_data};
                for (int i = 1; i < BELT_LEN; i++) belt_d[i] = belt_q[i-1];
            end
            OP_CALL: begin
                if (!stk_full) begin
                    for (int i = 0; i < BELT_LEN; i++)
                        belt_d[i] = (i < int'(call_n)) ? arg_pick[i] : '0;
                end
            end
            OP_RET: begin
                if (!stk_empty) begin
                    for (int i = 0; i < BELT_LEN; i++)
                        belt_d[i] = (i < int'(ret_n)) ? res_pick[i] : saved_shift[i];
                end
            end
            default: belt_d = belt_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) belt_q <= '0;
        else        belt_q <= belt_d;
    end

    // Error outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_overflow  <= 1'b0;
            err_underflow <= 1'b0;
        end else begin
            err_overflow  <= (op == OP_CALL) && stk_full;
            err_underflow <= (op == OP_RET) && stk_empty;
        end
    end
endmodule

// File: rtl/belt_frame_checker.sv
module belt_frame_checker
    import belt_pkg::*;
#(
    parameter int BELT_LEN = 8,
    parameter int MAX_ARGS = 4,
    parameter int CNT_W    = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       drop_valid,
    input logic [BELT_DATA_W-1:0]     drop_data,
    input logic                       call_valid,
    input logic [CNT_W-1:0]           call_cnt,
    input logic                       ret_valid,
    input logic                       stk_full,
    input logic                       stk_empty,
    input belt_entry_t [BELT_LEN-1:0] belt_q,
    input logic                       err_overflow,
    input logic                       err_underflow
);
    logic [BELT_LEN-1:0] valid_vec;
    always_comb begin
        for (int i = 0; i < BELT_LEN; i++) valid_vec[i] = belt_q[i].valid;
    end

    AST_DROP_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_valid && !call_valid && !ret_valid) |=> (belt_q[0].valid && belt_q[0].data == $past(drop_data))); // R3
    AST_DROP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_valid && !call_valid && !ret_valid) |=> (belt_q[BELT_LEN-1] == $past(belt_q[BELT_LEN-2]))); // R3
    AST_CALL_NAR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && !stk_full) |=> ($countones(valid_vec) <= MAX_ARGS)); // R5
    AST_CALL_EMPTY_ARGS: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && !stk_full && call_cnt == '0) |=> (valid_vec == '0)); // R5
    AST_NO_OVERFLOW_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && stk_full) |=> (err_overflow && belt_q == $past(belt_q))); // R8
    AST_NO_UNDERFLOW_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_valid && ret_valid && stk_empty) |=> (err_underflow && belt_q == $past(belt_q))); // R9
    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_overflow && err_underflow)); // R10
endmodule

bind belt_frame_unit belt_frame_checker #(
    .BELT_LEN (BELT_LEN),
    .MAX_ARGS (MAX_ARGS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .drop_valid    (drop_valid),
    .drop_data     (drop_data),
    .call_valid    (call_valid),
    .call_cnt      (call_cnt),
    .ret_valid     (ret_valid),
    .stk_full      (stk_full),
    .stk_empty     (stk_empty),
    .belt_q        (belt_q),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
);

// File: tb/belt_frame_unit_tb.sv
`timescale 1ns/1ps
module belt_frame_unit_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              drop_valid = 1'b0;
    logic [15:0]       drop_data = '0;
    logic [1:0][3:0]   rd_idx = '0;
    logic [1:0][15:0]  rd_data;
    logic [1:0]        rd_valid;
    logic              call_valid = 1'b0;
    logic [2:0]        call_cnt = '0;
    logic [3:0][3:0]   call_idx = '0;
    logic              ret_valid = 1'b0;
    logic [2:0]        ret_cnt = '0;
    logic [3:0][3:0]   ret_idx = '0;
    logic              err_overflow, err_underflow;

    always #2.5 clk = ~clk;

    belt_frame_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .drop_valid(drop_valid), .drop_data(drop_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .call_valid(call_valid), .call_cnt(call_cnt), .call_idx(call_idx),
        .ret_valid(ret_valid), .ret_cnt(ret_cnt), .ret_idx(ret_idx),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    typedef struct packed { logic v; logic [15:0] d; } ment_t;
    typedef struct { int kind; logic v; logic [15:0] d; string req; } sb_item_t;

    sb_item_t sb[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    ment_t mb [8];
    ment_t mstk [4][8];
    int    msp = 0;

    // Monitor: compare all expectations queued for this cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            logic av;
            logic [15:0] ad;
            it = sb.pop_front();
            ad = '0;
            case (it.kind)
                0: begin av = rd_valid[0]; ad = rd_data[0]; end
                1: begin av = rd_valid[1]; ad = rd_data[1]; end
                2: av = err_overflow;
                default: av = err_underflow;
            endcase
            checks++;
            if (av !== it.v || (it.kind < 2 && ad !== it.d)) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%b/%h expected=%b/%h",
                         it.req, it.kind, av, ad, it.v, it.d);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input int kind, input logic v, input logic [15:0] d, input string req);
        sb_item_t it;
        it.kind = kind; it.v = v; it.d = d; it.req = req;
        sb.push_back(it);
    endtask

    function automatic ment_t mpick(input int idx);
        if (idx >= 0 && idx < 8) return mb[idx];
        return '0;
    endfunction

    task automatic verify_belt(input string req);
        for (int c = 0; c < 4; c++) begin
            rd_idx[0] = 4'(2*c);
            rd_idx[1] = 4'(2*c + 1);
            expect_item(0, mb[2*c].v, mb[2*c].d, req);
            expect_item(1, mb[2*c+1].v, mb[2*c+1].d, req);
            step();
        end
    endtask

    task automatic verify_oor(input string req);
        rd_idx[0] = 4'd8;
        rd_idx[1] = 4'd15;
        expect_item(0, 1'b0, 16'h0, req);
        expect_item(1, 1'b0, 16'h0, req);
        step();
    endtask

    task automatic run_cmd(input bit dv, input logic [15:0] dd,
                           input bit cv, input int cc, input int ci [4],
                           input bit rv, input int rc, input int ri [4],
                           input string req);
        ment_t nb [8];
        bit eo, eu;
        eo = 1'b0; eu = 1'b0;
        nb = mb;
        if (cv) begin
            if (msp == 4) eo = 1'b1;
            else begin
                int n;
                n = (cc > 4) ? 4 : cc;
                for (int k = 0; k < 8; k++) mstk[msp][k] = mb[k];
                msp++;
                for (int k = 0; k < 8; k++) nb[k] = (k < n) ? mpick(ci[k < 4 ? k : 0]) : '0;
            end
        end else if (rv) begin
            if (msp == 0) eu = 1'b1;
            else begin
                int n;
                n = (rc > 4) ? 4 : rc;
                msp--;
                for (int k = 0; k < 8; k++)
                    nb[k] = (k < n) ? mpick(ri[k < 4 ? k : 0]) : mstk[msp][k < n ? 0 : k - n];
            end
        end else if (dv) begin
            for (int k = 7; k > 0; k--) nb[k] = mb[k-1];
            nb[0] = {1'b1, dd};
        end
        drop_valid = dv; drop_data = dd;
        call_valid = cv; call_cnt = 3'(cc);
        ret_valid = rv;  ret_cnt = 3'(rc);
        for (int k = 0; k < 4; k++) begin
            call_idx[k] = 4'(ci[k]);
            ret_idx[k]  = 4'(ri[k]);
        end
        step();
        drop_valid = 1'b0; call_valid = 1'b0; ret_valid = 1'b0;
        mb = nb;
        expect_item(2, eo, 16'h0, req);
        expect_item(3, eu, 16'h0, req);
        verify_belt(req);
    endtask

    task automatic do_drop(input logic [15:0] d, input string req);
        run_cmd(1'b1, d, 1'b0, 0, '{0,0,0,0}, 1'b0, 0, '{0,0,0,0}, req);
    endtask

    task automatic do_call(input int cnt, input int ci [4], input string req);
        run_cmd(1'b0, 16'h0, 1'b1, cnt, ci, 1'b0, 0, '{0,0,0,0}, req);
    endtask

    task automatic do_ret(input int cnt, input int ri [4], input string req);
        run_cmd(1'b0, 16'h0, 1'b0, 0, '{0,0,0,0}, 1'b1, cnt, ri, req);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) mb[k] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, then R2 out-of-range reads
        expect_item(2, 1'b0, 16'h0, "R1");
        expect_item(3, 1'b0, 16'h0, "R1");
        verify_belt("R1");
        verify_oor("R2");
        // R3: drops fill the belt and push old values off the tail
        for (int i = 0; i < 10; i++) do_drop(16'h1100 + 16'(i), "R3");
        verify_oor("R2");
        // R4: call with selected arguments
        do_call(3, '{1,4,3,0}, "R4");
        do_drop(16'hA001, "R3");
        do_drop(16'hA002, "R3");
        // R6: return with an out-of-range index in the list
        do_ret(2, '{0,9,0,0}, "R6");
        // R4: out-of-range call argument
        do_call(2, '{12,0,0,0}, "R4");
        do_ret(1, '{1,0,0,0}, "R6");
        // R5: count above the limit is clamped
        do_call(6, '{0,1,2,3}, "R5");
        do_ret(0, '{0,0,0,0}, "R6");
        // R7: four nested calls, each carrying its own marker
        for (int lvl = 0; lvl < 4; lvl++) begin
            do_drop(16'hC000 + 16'(lvl), "R7");
            do_call(1, '{0,0,0,0}, "R7");
        end
        // R8: overflow with a competing drop
        run_cmd(1'b1, 16'hDEAD, 1'b1, 2, '{0,1,0,0}, 1'b0, 0, '{0,0,0,0}, "R8");
        for (int lvl = 0; lvl < 4; lvl++) do_ret(1, '{0,0,0,0}, "R7");
        // R9: underflow with a competing drop
        run_cmd(1'b1, 16'hBEEF, 1'b0, 0, '{0,0,0,0}, 1'b1, 1, '{0,0,0,0}, "R9");
        // R10: all three at once, then return against drop
        run_cmd(1'b1, 16'h5151, 1'b1, 2, '{0,2,0,0}, 1'b1, 1, '{0,0,0,0}, "R10");
        run_cmd(1'b1, 16'h5252, 1'b0, 0, '{0,0,0,0}, 1'b1, 2, '{1,0,0,0}, "R10");
        do_drop(16'h5353, "R10");
        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (R1..R10 run) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule